// File: doc/BRIEF.md
# Register-File Datapath with Function Unit

This block is a single-cycle datapath. It holds four parallel-load registers, each addressed by a 2-bit code. Two read selectors take registers out onto two operand buses. The first operand bus also leaves the block as an address output. The second operand bus is either a register or an external constant, and it leaves the block as a data output. A function unit holds an arithmetic/logic unit and a separate shifter, and an output mux picks one of the two. A write-back mux then chooses between the function result and an external data input, and the chosen value goes back into the register file.

All control arrives as one flat set of select and enable inputs at the ports. A small control module turns the destination code and the global write enable into per-register load strobes. A register-to-register operation such as adding two registers and placing the sum in a third takes exactly one clock. The status flags are combinational and follow the current function output.

Top module: `regfile_datapath`

## Requirements
- R1: While `rstN` is low, all four registers are cleared to zero. Reading any register on `addrOut` after reset returns 0.
- R2: `addrOut` always shows the register whose index is on `aSel`. The index codes are 0 to 3.
- R3: With `mbSel`=0, `dataOut` shows the register selected by `bSel`. With `mbSel`=1, it shows `constIn`, and the function unit's B operand is also `constIn`.
- R4: On a rising clock edge, only the register whose index equals `destSel` is written, and only if `loadEn` is 1. With `loadEn`=0, no register changes.
- R5: When `gSel[3]`=0, the ALU result is as follows: 0000 gives A, 0001 gives A+1, 0010 gives A+B, 0011 gives A+B+1, 0100 gives A+~B, 0101 gives A−B, 0110 gives A−1, and 0111 gives A. All results are taken modulo 2^W.
- R6: When `gSel[3]`=1, the operation depends on `gSel[2:1]`: 00 is A AND B, 01 is A OR B, 10 is A XOR B, and 11 is NOT A. `gSel[0]` is ignored.
- R7: With `mfSel`=1, the function output comes from the shifter. With `hSel`=00 it is B. With `hSel`=01 it is B shifted right by one, with `shiftInR` entering the MSB. With `hSel`=10 it is B shifted left by one, with `shiftInL` entering the LSB. With `hSel`=11 it is B.
- R8: With `mdSel`=1, the register write takes `dataIn`. With `mdSel`=0, it takes the function output.
- R9: For arithmetic codes, `flagC` is the carry out of the W-bit addition and `flagV` is two's-complement overflow. For logic codes (`gSel[3]`=1), both flags are 0.
- R10: `flagN` equals the MSB of the function output. `flagZ` is 1 exactly when the function output is zero.
- R11: A register-to-register operation completes in one clock. An example is R0 ← R1 + R2, using aSel=01, bSel=10, mbSel=0, gSel=0010, mfSel=0, mdSel=0, destSel=00 and loadEn=1. The result can be read on `addrOut` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Global register write enable |
| destSel | input | 2 | Destination register index |
| aSel | input | 2 | Register index for bus A |
| bSel | input | 2 | Register index for register data B |
| mbSel | input | 1 | Bus B source: 0 register, 1 constant |
| gSel | input | 4 | ALU operation code |
| hSel | input | 2 | Shifter operation code |
| mfSel | input | 1 | Function output: 0 ALU, 1 shifter |
| mdSel | input | 1 | Write-back source: 0 function output, 1 dataIn |
| constIn | input | W | External constant for bus B |
| dataIn | input | W | External write-back data |
| shiftInR | input | 1 | Serial bit entering MSB on right shift |
| shiftInL | input | 1 | Serial bit entering LSB on left shift |
| addrOut | output | W | Bus A |
| dataOut | output | W | Bus B |
| flagV | output | 1 | Signed overflow |
| flagC | output | 1 | Carry out |
| flagN | output | 1 | Negative (MSB of function output) |
| flagZ | output | 1 | Zero detect on function output |

## Verification
The buses and flags are combinational. They are due in the same cycle as the selects that drive them. The bench therefore sets the selects just after a clock edge and samples a short settle time later, well before the next edge. A register write becomes visible one edge after `loadEn` is applied, so each write-back is checked by moving `aSel` to the destination after that single edge and reading `addrOut`. Reset clearing is checked the same way, by reading each register after `rstN` is released.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int SEL_W     = 2;
  localparam int REG_COUNT = 1 << SEL_W;
  localparam int G_W       = 4;
  localparam int H_W       = 2;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_HOLD  = 2'b11
  } shiftOp_e;

  typedef struct packed {
    logic [REG_COUNT-1:0] regLoad;
    logic [SEL_W-1:0]     aSel;
    logic [SEL_W-1:0]     bSel;
    logic                 useConst;
    logic [G_W-1:0]       gSel;
    logic [H_W-1:0]       hSel;
    logic                 pickShift;
    logic                 pickExt;
  } dpStrobes_t;
endpackage

// File: rtl/dp_ctrl.sv
module dp_ctrl
  import dp_pkg::*;
(
  input  logic             loadEn,
  input  logic [SEL_W-1:0] destSel,
  input  logic [SEL_W-1:0] aSel,
  input  logic [SEL_W-1:0] bSel,
  input  logic             mbSel,
  input  logic [G_W-1:0]   gSel,
  input  logic [H_W-1:0]   hSel,
  input  logic             mfSel,
  input  logic             mdSel,
  output dpStrobes_t       strobes
);
  logic [REG_COUNT-1:0] loadVec;

  // destination decoder gated by the global enable
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_dec
    assign loadVec[i] = loadEn && (destSel == SEL_W'(i));
  end

  always_comb begin
    strobes.regLoad   = loadVec;
    strobes.aSel      = aSel;
    strobes.bSel      = bSel;
    strobes.useConst  = mbSel;
    strobes.gSel      = gSel;
    strobes.hSel      = hSel;
    strobes.pickShift = mfSel;
    strobes.pickExt   = mdSel;
  end
endmodule

// File: rtl/dp_func.sv
module dp_func
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [G_W-1:0] gSel,
  input  logic [H_W-1:0] hSel,
  input  logic           pickShift,
  input  logic           shiftInR,
  input  logic           shiftInL,
  output logic [W-1:0]   funcOut,
  output logic           vOut,
  output logic           cOut,
  output logic           nOut,
  output logic           zOut
);
  localparam int MSB = W - 1;

  logic [W-1:0] yOp;
  logic [W:0]   sum;
  logic [W-1:0] logicRes;
  logic [W-1:0] aluRes;
  logic [W-1:0] shiftRes;
  logic         isLogic;

  assign isLogic = gSel[3];

  // B-side operand for the adder: zero, B, ~B or all ones
  always_comb begin
    unique case (gSel[2:1])
      2'b00:   yOp = '0;
      2'b01:   yOp = opB;
      2'b10:   yOp = ~opB;
      default: yOp = '1;
    endcase
  end

  assign sum = {1'b0, opA} + {1'b0, yOp} + (W+1)'(gSel[0]);

  always_comb begin
    unique case (gSel[2:1])
      2'b00:   logicRes = opA & opB;
      2'b01:   logicRes = opA | opB;
      2'b10:   logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
  end

  assign aluRes = isLogic ? logicRes : sum[W-1:0];
  assign cOut   = !isLogic && sum[W];
  assign vOut   = !isLogic && (opA[MSB] == yOp[MSB]) && (sum[MSB] != opA[MSB]);

  always_comb begin
    unique case (shiftOp_e'(hSel))
      SH_RIGHT: shiftRes = {shiftInR, opB[W-1:1]};
      SH_LEFT:  shiftRes = {opB[W-2:0], shiftInL};
      default:  shiftRes = opB;
    endcase
  end

  assign funcOut = pickShift ? shiftRes : aluRes;
  assign nOut    = funcOut[MSB];
  assign zOut    = (funcOut == '0);
endmodule

// File: rtl/dp_core.sv
module dp_core
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobes_t   strobes,
  input  logic [W-1:0] constIn,
  input  logic [W-1:0] dataIn,
  input  logic         shiftInR,
  input  logic         shiftInL,
  output logic [W-1:0] addrOut,
  output logic [W-1:0] dataOut,
  output logic         flagV,
  output logic         flagC,
  output logic         flagN,
  output logic         flagZ
);
  logic [W-1:0] regs [REG_COUNT];
  logic [W-1:0] busA;
  logic [W-1:0] regB;
  logic [W-1:0] busB;
  logic [W-1:0] funcOut;
  logic [W-1:0] busD;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   regs[i] <= '0;
      else if (strobes.regLoad[i]) regs[i] <= busD;
    end
  end

  assign busA = regs[strobes.aSel];
  assign regB = regs[strobes.bSel];
  assign busB = strobes.useConst ? constIn : regB;

  dp_func #(.W(W)) func_i (
    .opA       (busA),
    .opB       (busB),
    .gSel      (strobes.gSel),
    .hSel      (strobes.hSel),
    .pickShift (strobes.pickShift),
    .shiftInR  (shiftInR),
    .shiftInL  (shiftInL),
    .funcOut   (funcOut),
    .vOut      (flagV),
    .cOut      (flagC),
    .nOut      (flagN),
    .zOut      (flagZ)
  );

  assign busD    = strobes.pickExt ? dataIn : funcOut;
  assign addrOut = busA;
  assign dataOut = busB;
endmodule

// File: rtl/regfile_datapath.sv
module regfile_datapath
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [SEL_W-1:0] destSel,
  input  logic [SEL_W-1:0] aSel,
  input  logic [SEL_W-1:0] bSel,
  input  logic             mbSel,
  input  logic [G_W-1:0]   gSel,
  input  logic [H_W-1:0]   hSel,
  input  logic             mfSel,
  input  logic             mdSel,
  input  logic [W-1:0]     constIn,
  input  logic [W-1:0]     dataIn,
  input  logic             shiftInR,
  input  logic             shiftInL,
  output logic [W-1:0]     addrOut,
  output logic [W-1:0]     dataOut,
  output logic             flagV,
  output logic             flagC,
  output logic             flagN,
  output logic             flagZ
);
  dpStrobes_t strobes;

  dp_ctrl ctrl_i (
    .loadEn  (loadEn),
    .destSel (destSel),
    .aSel    (aSel),
    .bSel    (bSel),
    .mbSel   (mbSel),
    .gSel    (gSel),
    .hSel    (hSel),
    .mfSel   (mfSel),
    .mdSel   (mdSel),
    .strobes (strobes)
  );

  dp_core #(.W(W)) core_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .constIn  (constIn),
    .dataIn   (dataIn),
    .shiftInR (shiftInR),
    .shiftInL (shiftInL),
    .addrOut  (addrOut),
    .dataOut  (dataOut),
    .flagV    (flagV),
    .flagC    (flagC),
    .flagN    (flagN),
    .flagZ    (flagZ)
  );
endmodule

// File: rtl/dp_checker.sv
module dp_checker
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadEn,
  input logic [SEL_W-1:0] destSel,
  input logic [SEL_W-1:0] aSel,
  input logic             mbSel,
  input logic             mdSel,
  input logic [G_W-1:0]   gSel,
  input logic [W-1:0]     constIn,
  input logic [W-1:0]     dataIn,
  input logic [W-1:0]     addrOut,
  input logic [W-1:0]     dataOut,
  input logic             flagV,
  input logic             flagC,
  input logic             flagN,
  input logic             flagZ
);
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> (aSel != $past(aSel)) || $stable(addrOut)); // R4

  AST_EXT_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && mdSel && destSel == aSel) |=>
      (aSel != $past(aSel)) || (addrOut == $past(dataIn))); // R8

  AST_CONST_ON_BUS_B: assert property (@(posedge clk) disable iff (!rstN)
    mbSel |-> dataOut == constIn); // R3

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    gSel[3] |-> !flagC && !flagV); // R9

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
    flagZ |-> !flagN); // R10
endmodule

bind regfile_datapath dp_checker #(.W(W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .loadEn  (loadEn),
  .destSel (destSel),
  .aSel    (aSel),
  .mbSel   (mbSel),
  .mdSel   (mdSel),
  .gSel    (gSel),
  .constIn (constIn),
  .dataIn  (dataIn),
  .addrOut (addrOut),
  .dataOut (dataOut),
  .flagV   (flagV),
  .flagC   (flagC),
  .flagN   (flagN),
  .flagZ   (flagZ)
);

// File: tb/regfile_datapath_tb.sv
`timescale 1ns/1ps
module regfile_datapath_tb_top;
  localparam int W = 8;
  localparam int NV = 16;

  // vector layout: {A[7:0], B[7:0], G[3:0]}
  localparam logic [19:0] VEC [NV] = '{
    {8'h05, 8'h03, 4'b0010}, {8'h7F, 8'h01, 4'b0010},
    {8'hFF, 8'h01, 4'b0010}, {8'h10, 8'h01, 4'b0101},
    {8'h80, 8'h01, 4'b0101}, {8'h03, 8'h00, 4'b0001},
    {8'h00, 8'h00, 4'b0110}, {8'h05, 8'h03, 4'b0011},
    {8'h05, 8'h03, 4'b0100}, {8'h42, 8'h11, 4'b0000},
    {8'h42, 8'h11, 4'b0111}, {8'hF0, 8'h3C, 4'b1000},
    {8'hF0, 8'h3C, 4'b1010}, {8'hF0, 8'h3C, 4'b1101},
    {8'hF0, 8'h3C, 4'b1110}, {8'h7F, 8'h7F, 4'b0010}
  };

  logic clk = 0, rstN = 0, loadEn = 0, mbSel = 0, mfSel = 0, mdSel = 0;
  logic shiftInR = 0, shiftInL = 0;
  logic [1:0] destSel = 0, aSel = 0, bSel = 0, hSel = 0;
  logic [3:0] gSel = 0;
  logic [W-1:0] constIn = 0, dataIn = 0;
  logic [W-1:0] addrOut, dataOut;
  logic flagV, flagC, flagN, flagZ;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regfile_datapath #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .destSel(destSel), .aSel(aSel),
    .bSel(bSel), .mbSel(mbSel), .gSel(gSel), .hSel(hSel), .mfSel(mfSel),
    .mdSel(mdSel), .constIn(constIn), .dataIn(dataIn), .shiftInR(shiftInR),
    .shiftInL(shiftInL), .addrOut(addrOut), .dataOut(dataOut),
    .flagV(flagV), .flagC(flagC), .flagN(flagN), .flagZ(flagZ)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepClk();
    @(posedge clk); #2;
  endtask

  task automatic writeReg(input logic [1:0] idx, input logic [W-1:0] val);
    mdSel = 1; dataIn = val; destSel = idx; loadEn = 1;
    stepClk();
    loadEn = 0; mdSel = 0;
  endtask

  task automatic readReg(input logic [1:0] idx, output logic [W-1:0] val);
    aSel = idx; #1; val = addrOut;
  endtask

  // reference: {V, C, result}
  function automatic logic [9:0] refAlu(input logic [7:0] a, input logic [7:0] b, input logic [3:0] g);
    int ua = a, ub = b, sa = int'($signed(a)), sb = int'($signed(b));
    int us = 0, ss = 0;
    logic [7:0] r;
    if (g[3]) begin
      case (g[2:1])
        2'b00: r = a & b;
        2'b01: r = a | b;
        2'b10: r = a ^ b;
        default: r = ~a;
      endcase
      return {2'b00, r};
    end
    case (g[2:0])
      3'd0: begin us = ua;             ss = sa;          end
      3'd1: begin us = ua + 1;         ss = sa + 1;      end
      3'd2: begin us = ua + ub;        ss = sa + sb;     end
      3'd3: begin us = ua + ub + 1;    ss = sa + sb + 1; end
      3'd4: begin us = ua + 255 - ub; ss = sa - sb - 1; end
      3'd5: begin us = ua + 256 - ub; ss = sa - sb;     end
      3'd6: begin us = ua + 255;       ss = sa - 1;      end
      default: begin us = ua + 256;   ss = sa;          end
    endcase
    r = us[7:0];
    return {(ss > 127 || ss < -128), (us > 255), r};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [9:0] e;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    stepClk();
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      readReg(2'(i), v); check("R1 reset clear", v, 0);
    end

    // R2 / R4: distinct writes, each read back via bus A
    writeReg(0, 8'hA0); writeReg(1, 8'hB1); writeReg(2, 8'hC2); writeReg(3, 8'hD3);
    for (int i = 0; i < 4; i++) begin
      readReg(2'(i), v); check("R2 bus A select", v, {4'hA + 4'(i), 4'(i)});
    end

    // R4: loadEn low leaves all registers untouched
    mdSel = 1; dataIn = 8'h55; destSel = 1; loadEn = 0;
    stepClk(); mdSel = 0;
    readReg(1, v); check("R4 no write without loadEn", v, 8'hB1);
    readReg(0, v); check("R4 other reg untouched", v, 8'hA0);

    // R3: B mux
    bSel = 3; mbSel = 0; #1; check("R3 register on bus B", dataOut, 8'hD3);
    constIn = 8'h3E; mbSel = 1; #1; check("R3 constant on bus B", dataOut, 8'h3E);
    aSel = 0; gSel = 4'b0010; mfSel = 0; #1;
    check("R3 constant feeds ALU", {flagC, 8'(addrOut + constIn)}, {1'b0, 8'hDE});
    mbSel = 0;

    // R5/R6/R9/R10 table walk, writing back through R0 (R11 path)
    for (int i = 0; i < NV; i++) begin
      logic [7:0] a, b; logic [3:0] g;
      {a, b, g} = VEC[i];
      writeReg(1, a); writeReg(2, b);
      aSel = 1; bSel = 2; mbSel = 0; mfSel = 0; mdSel = 0; gSel = g; #1;
      e = refAlu(a, b, g);
      check("R9 flag V", flagV, e[9]);
      check("R9 flag C", flagC, e[8]);
      check("R10 flag N", flagN, e[7]);
      check("R10 flag Z", flagZ, (e[7:0] == 0));
      destSel = 0; loadEn = 1; stepClk(); loadEn = 0;
      readReg(0, v);
      check(g[3] ? "R6 logic result" : "R5 arith result", v, e[7:0]);
    end

    // R11: R0 <- R1 + R2 in a single clock
    writeReg(1, 8'h21); writeReg(2, 8'h14);
    aSel = 1; bSel = 2; mbSel = 0; gSel = 4'b0010; mfSel = 0; mdSel = 0;
    destSel = 0; loadEn = 1; stepClk(); loadEn = 0;
    readReg(0, v); check("R11 one-clock add", v, 8'h35);

    // R7 shifter with R10 on its output
    writeReg(2, 8'h81);
    aSel = 0; bSel = 2; mbSel = 0; mfSel = 1; gSel = 4'b0000;
    hSel = 2'b00; #1; check("R7 shifter pass", flagN, 1'b1);
    hSel = 2'b01; shiftInR = 0; destSel = 3; loadEn = 1; stepClk(); loadEn = 0;
    readReg(3, v); check("R7 shift right IR=0", v, 8'h40);
    hSel = 2'b01; shiftInR = 1; loadEn = 1; stepClk(); loadEn = 0;
    readReg(3, v); check("R7 shift right IR=1", v, 8'hC0);
    hSel = 2'b10; shiftInL = 1; loadEn = 1; stepClk(); loadEn = 0;
    readReg(3, v); check("R7 shift left IL=1", v, 8'h03);
    hSel = 2'b11; loadEn = 1; stepClk(); loadEn = 0;
    readReg(3, v); check("R7 code 11 passes B", v, 8'h81);
    writeReg(2, 8'h01); aSel = 0; bSel = 2; mfSel = 1; hSel = 2'b01; shiftInR = 0; #1;
    check("R10 zero from shifter", flagZ, 1'b1);

    // R8: external data written with function unit active
    mfSel = 0; gSel = 4'b0010; mdSel = 1; dataIn = 8'h9C; destSel = 2; loadEn = 1;
    stepClk(); loadEn = 0; mdSel = 0;
    readReg(2, v); check("R8 dataIn write-back", v, 8'h9C);

    // R1: reset mid-run clears again
    #3 rstN = 0; #5 rstN = 1; stepClk();
    readReg(2, v); check("R1 reset after use", v, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule